// File: doc/BRIEF.md
# Mixed-Precision Multiply-Add

This block multiplies two half-precision floating-point operands and adds a single-precision addend. It produces one single-precision result that is rounded only once, at the end. No intermediate product rounding and no separate half-to-single conversion take place. A datapath built this way accumulates dot products of half-precision vectors into a single-precision sum with better accuracy than a half-precision multiply-add. Its latency is comparable.

The significand multiplier is only 11 by 11 bits. The alignment window and the adder behind it are sized for a 24-bit result. Both operands are placed relative to the larger of their leading-bit exponents. Bits of the smaller operand that fall out of the window collapse into a single sticky bit. Subnormal half-precision inputs produce products with up to 21 leading zeros. Close exponents can cancel almost every bit of the sum. A full leading-zero count and a left normalization recover the result in both cases.

The unit is fully pipelined in three register stages, and a new operation can enter on every clock.

Top module: `mixed_fma`

## Requirements
- R1: For finite inputs, `result` is the binary32 value nearest to the exact value of op_a × op_b + addend, with ties going to an even significand. Formats: half precision is sign bit 15, exponent bits 14:10 with bias 15, fraction bits 9:0. Single precision is sign bit 31, exponent bits 30:23 with bias 127, fraction bits 22:0.
- R2: An operation sampled with in_valid high on rising edge N appears on `result`, with out_valid high, after rising edge N+2. out_valid is low after every edge whose input two edges earlier was not valid. Operations may be issued on consecutive cycles.
- R3: A half-precision input with exponent field 0 is taken as 0.fraction × 2^-14, so products of subnormals as small as 2^-48 come out exact.
- R4: When the product and the addend have opposite signs and nearly equal magnitudes, the result is still the correctly rounded exact difference.
- R5: A NaN in any input (exponent all ones, non-zero fraction) gives 0x7FC00000.
- R6: Infinity times zero gives 0x7FC00000. So does an infinite product added to an infinite addend of the opposite sign.
- R7: Otherwise, an infinite operand produces an infinity. An infinite product takes the sign of op_a XOR op_b, and an infinite addend keeps its own sign.
- R8: An exact zero sum gives +0 (0x00000000). The only exception is a zero product whose sign is negative plus an addend of -0, which gives -0 (0x80000000).
- R9: When exactly one factor pair yields a zero product and the addend is finite and non-zero, `result` equals `addend` bit for bit, subnormal addends included.
- R10: While rst_n is low at a rising edge, out_valid and result are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on this cycle form an operation |
| op_a | input | 16 | First half-precision factor |
| op_b | input | 16 | Second half-precision factor |
| addend | input | 32 | Single-precision addend |
| out_valid | output | 1 | `result` holds a finished operation |
| result | output | 32 | Single-precision rounded sum |

## Verification
The latency and special-value properties compare outputs with inputs from three edges earlier. They therefore rely only on the inputs being driven to known values once reset is released. A warm-up counter keeps them quiet until three post-reset edges have passed. No property restricts the operand values. The stimulus mixes fully random encodings, including NaN and infinity, with finite half-precision factors whose exponent field is kept below all ones. Addends are aimed near the product, either as an exact negation with a small offset to provoke cancellation or with a nearby exponent. Every expected value comes from an exact integer model in units of 2^-149.

// File: rtl/mfma_pkg.sv
// Shared constants and the stage-one record of the mixed-precision multiply-add.
// Assumes binary16 factors and a binary32 addend and result.
package mfma_pkg;
    localparam int EXP_W = 10;          // signed exponent arithmetic width
    localparam int HM_W  = 11;          // half-precision significand width
    localparam int PM_W  = 2 * HM_W;    // exact product significand width
    localparam int CM_W  = 24;          // single-precision significand width
    localparam logic [31:0] QNAN32 = 32'h7FC0_0000;

    typedef logic signed [EXP_W-1:0] exp_t;

    typedef struct packed {
        logic            bypass;     // result fixed by special-case rules
        logic [31:0]     bypass_val;
        logic            p_sign;
        logic [PM_W-1:0] p_mag;      // exact product significand
        exp_t            p_top;      // weight exponent of product bit PM_W-1
        logic            c_sign;
        logic [CM_W-1:0] c_mag;
        exp_t            c_top;      // weight exponent of addend bit CM_W-1
    } dec_t;
endpackage

// File: rtl/mfma_decode.sv
// Stage one: unpacks both factors and the addend, forms the exact product
// significand and decides every special case (NaN, infinity, zero product).
// Assumes nothing about input values; all encodings are legal.
module mfma_decode
    import mfma_pkg::*;
(
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    input  logic [31:0] addend,
    output dec_t        dec
);
    logic [4:0]      ea, eb;
    logic [7:0]      ec;
    logic            a_nan, b_nan, c_nan, a_inf, b_inf, c_inf;
    logic            a_zero, b_zero, c_zero;
    logic [HM_W-1:0] ma, mb;
    exp_t            xa, xb, xc;
    logic            p_sign;

    assign ea = op_a[14:10];
    assign eb = op_b[14:10];
    assign ec = addend[30:23];

    // Classify each field into NaN, infinity and zero.
    always_comb begin : classify
        a_nan  = (ea == 5'h1F) && (op_a[9:0] != '0);
        b_nan  = (eb == 5'h1F) && (op_b[9:0] != '0);
        c_nan  = (ec == 8'hFF) && (addend[22:0] != '0);
        a_inf  = (ea == 5'h1F) && (op_a[9:0] == '0);
        b_inf  = (eb == 5'h1F) && (op_b[9:0] == '0);
        c_inf  = (ec == 8'hFF) && (addend[22:0] == '0);
        a_zero = (op_a[14:0] == '0);
        b_zero = (op_b[14:0] == '0);
        c_zero = (addend[30:0] == '0);
    end

    // Significands and unbiased exponents; subnormals use a hidden 0.
    always_comb begin : unpack
        ma = {ea != '0, op_a[9:0]};
        mb = {eb != '0, op_b[9:0]};
        xa = (ea == '0) ? exp_t'(-14)  : exp_t'({5'b0, ea}) - exp_t'(15);
        xb = (eb == '0) ? exp_t'(-14)  : exp_t'({5'b0, eb}) - exp_t'(15);
        xc = (ec == '0) ? exp_t'(-126) : exp_t'({2'b0, ec}) - exp_t'(127);
        p_sign = op_a[15] ^ op_b[15];
    end

    // Build the stage record, with special results overriding the datapath.
    always_comb begin : build_record
        dec.p_sign     = p_sign;
        dec.p_mag      = {{HM_W{1'b0}}, ma} * {{HM_W{1'b0}}, mb};
        dec.p_top      = xa + xb + exp_t'(1);
        dec.c_sign     = addend[31];
        dec.c_mag      = {ec != '0, addend[22:0]};
        dec.c_top      = xc;
        dec.bypass     = 1'b1;
        dec.bypass_val = QNAN32;
        if (a_nan || b_nan || c_nan || (a_inf && b_zero) || (b_inf && a_zero)) begin
            dec.bypass_val = QNAN32;
        end else if (a_inf || b_inf) begin
            dec.bypass_val = (c_inf && (addend[31] != p_sign)) ? QNAN32
                                                               : {p_sign, 8'hFF, 23'b0};
        end else if (c_inf) begin
            dec.bypass_val = addend;
        end else if (a_zero || b_zero) begin
            dec.bypass_val = c_zero ? {p_sign & addend[31], 31'b0} : addend;
        end else begin
            dec.bypass     = 1'b0;
        end
    end
endmodule

// File: rtl/mfma_align_add.sv
// Stage two: aligns product and addend below the larger leading exponent in
// a WIN_W-bit window, folds dropped bits into a sticky bit and forms the
// signed-magnitude sum. Assumes both operands are finite and the product non-zero.
module mfma_align_add
    import mfma_pkg::*;
#(
    parameter int WIN_W = 99
) (
    input  logic            p_sign,
    input  logic [PM_W-1:0] p_mag,
    input  exp_t            p_top,
    input  logic            c_sign,
    input  logic [CM_W-1:0] c_mag,
    input  exp_t            c_top,
    output logic            sum_sign,
    output logic [WIN_W+1:0] sum_mag,
    output exp_t            anchor
);
    localparam int SUM_W = WIN_W + 2;

    exp_t             sh_p, sh_c;
    logic [SUM_W-1:0] p_ext, c_ext;

    // Right shift of a top-justified value with sticky collection.
    function automatic logic [WIN_W:0] align_right(input logic [WIN_W-1:0] v, input exp_t sh);
        logic [2*WIN_W-1:0] wide;
        int                 amt;
        amt  = (sh > exp_t'(WIN_W)) ? WIN_W : int'(sh);
        wide = {v, {WIN_W{1'b0}}} >> amt;
        return {wide[2*WIN_W-1:WIN_W], |wide[WIN_W-1:0]};
    endfunction

    // Pick the anchor and the shift of each operand.
    always_comb begin : pick_anchor
        anchor = (p_top > c_top) ? p_top : c_top;
        sh_p   = anchor - p_top;
        sh_c   = anchor - c_top;
        p_ext  = {1'b0, align_right({p_mag, {(WIN_W-PM_W){1'b0}}}, sh_p)};
        c_ext  = {1'b0, align_right({c_mag, {(WIN_W-CM_W){1'b0}}}, sh_c)};
    end

    // Effective add or subtract, larger minus smaller, exact zero is positive.
    always_comb begin : add_sub
        if (p_sign == c_sign) begin
            sum_mag  = p_ext + c_ext;
            sum_sign = p_sign;
        end else if (p_ext >= c_ext) begin
            sum_mag  = p_ext - c_ext;
            sum_sign = p_sign;
        end else begin
            sum_mag  = c_ext - p_ext;
            sum_sign = c_sign;
        end
        if (sum_mag == '0) begin
            sum_sign = 1'b0;
        end
    end
endmodule

// File: rtl/mfma_round.sv
// Stage three: counts leading zeros of the sum, normalizes it and rounds to
// binary32 with ties to even. Assumes the sum is either zero or lands in
// the normal binary32 range (guaranteed for a non-zero binary16 product).
module mfma_round
    import mfma_pkg::*;
#(
    parameter int WIN_W = 99
) (
    input  logic             sum_sign,
    input  logic [WIN_W+1:0] sum_mag,
    input  exp_t             anchor,
    output logic [31:0]      packed_out
);
    localparam int SUM_W = WIN_W + 2;
    localparam int LZ_W  = $clog2(SUM_W + 1);

    logic [LZ_W-1:0]  lz;
    logic [SUM_W-1:0] norm;
    logic [22:0]      mant;
    logic             rbit, sticky, rnd_up;
    logic [23:0]      m_sum;
    exp_t             e_pre, e_fin;

    // Leading-zero count; the highest set bit wins.
    always_comb begin : count_zeros
        lz = LZ_W'(SUM_W);
        for (int i = 0; i < SUM_W; i++) begin
            if (sum_mag[i]) lz = LZ_W'(SUM_W - 1 - i);
        end
    end

    // Normalize, round to nearest even and pack.
    always_comb begin : norm_round
        norm   = sum_mag << lz;
        mant   = norm[SUM_W-2 -: 23];
        rbit   = norm[SUM_W-25];
        sticky = |norm[SUM_W-26:0];
        rnd_up = rbit && (sticky || mant[0]);
        m_sum  = {1'b0, mant} + 24'(rnd_up);
        e_pre  = anchor + exp_t'(128) - exp_t'(lz);
        e_fin  = e_pre + exp_t'(m_sum[23]);
        packed_out = (sum_mag == '0) ? {sum_sign, 31'b0}
                                     : {sum_sign, e_fin[7:0], m_sum[22:0]};
    end
endmodule

// File: rtl/mixed_fma.sv
// Three-stage binary16 x binary16 + binary32 -> binary32 multiply-add with a
// single round-to-nearest-even step. Accepts one operation per cycle; the
// valid bit travels with the data. Synchronous active-low reset.
module mixed_fma
    import mfma_pkg::*;
#(
    parameter int WIN_W = 99
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    input  logic [31:0] addend,
    output logic        out_valid,
    output logic [31:0] result
);
    localparam int SUM_W = WIN_W + 2;

    dec_t             dec_d, s1_dec;
    logic             s1_valid;
    logic             sum_sign_d, s2_sign, s2_valid, s2_bypass;
    logic [SUM_W-1:0] sum_mag_d, s2_mag;
    exp_t             anchor_d, s2_anchor;
    logic [31:0]      s2_bypass_val, rounded;

    mfma_decode u_decode (
        .op_a   (op_a),
        .op_b   (op_b),
        .addend (addend),
        .dec    (dec_d)
    );

    // Stage-one register: decoded operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_dec   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_dec   <= dec_d;
        end
    end

    mfma_align_add #(.WIN_W(WIN_W)) u_align_add (
        .p_sign   (s1_dec.p_sign),
        .p_mag    (s1_dec.p_mag),
        .p_top    (s1_dec.p_top),
        .c_sign   (s1_dec.c_sign),
        .c_mag    (s1_dec.c_mag),
        .c_top    (s1_dec.c_top),
        .sum_sign (sum_sign_d),
        .sum_mag  (sum_mag_d),
        .anchor   (anchor_d)
    );

    // Stage-two register: unnormalized sum and special-case result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid      <= 1'b0;
            s2_bypass     <= 1'b0;
            s2_bypass_val <= '0;
            s2_sign       <= 1'b0;
            s2_mag        <= '0;
            s2_anchor     <= '0;
        end else begin
            s2_valid      <= s1_valid;
            s2_bypass     <= s1_dec.bypass;
            s2_bypass_val <= s1_dec.bypass_val;
            s2_sign       <= sum_sign_d;
            s2_mag        <= sum_mag_d;
            s2_anchor     <= anchor_d;
        end
    end

    mfma_round #(.WIN_W(WIN_W)) u_round (
        .sum_sign   (s2_sign),
        .sum_mag    (s2_mag),
        .anchor     (s2_anchor),
        .packed_out (rounded)
    );

    // Output register: rounded or special result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s2_valid;
            result    <= s2_bypass ? s2_bypass_val : rounded;
        end
    end
endmodule

// File: rtl/mixed_fma_chk.sv
// Property checker for mixed_fma, bound to every instance of it. Relates
// outputs to the inputs three edges earlier once three post-reset edges passed.
module mixed_fma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] op_a,
    input logic [15:0] op_b,
    input logic [31:0] addend,
    input logic        out_valid,
    input logic [31:0] result
);
    logic [1:0] warm;
    logic       any_nan, inf_zero, plain_pass;

    // Count edges since reset release, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // Input classifications watched by the properties.
    always_comb begin : watch_inputs
        any_nan  = ((op_a[14:10] == 5'h1F) && (op_a[9:0] != '0)) ||
                   ((op_b[14:10] == 5'h1F) && (op_b[9:0] != '0)) ||
                   ((addend[30:23] == 8'hFF) && (addend[22:0] != '0));
        inf_zero = (op_a[14:0] == 15'h7C00) && (op_b[14:0] == '0);
        plain_pass = ((op_a[14:0] == '0) && (op_b[14:10] != 5'h1F) &&
                      (addend[30:23] != 8'hFF) && (addend[30:0] != '0));
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_nan_canonical_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && out_valid && $past(any_nan, 3)) |-> (result == 32'h7FC0_0000));

    assert_nan_only_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[30:23] == 8'hFF && result[22:0] != '0) |-> (result == 32'h7FC0_0000));

    assert_inf_times_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && out_valid && $past(inf_zero, 3)) |-> (result == 32'h7FC0_0000));

    assert_neg_zero_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && out_valid && result == 32'h8000_0000) |-> ($past(addend, 3) == 32'h8000_0000));

    assert_zero_product_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && out_valid && $past(plain_pass, 3)) |-> (result == $past(addend, 3)));

    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));
endmodule

bind mixed_fma mixed_fma_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .addend    (addend),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/test_mixed_fma.sv
`timescale 1ns/1ps
module test_mixed_fma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [31:0] addend = '0;
    logic        out_valid;
    logic [31:0] result;

    int    n_checks = 0;
    int    n_err = 0;
    bit    finished = 0;
    logic  hv [3];
    logic [31:0] hr [3];
    string ht [3];

    always #2 clk = ~clk;

    mixed_fma i_mixed_fma (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .addend(addend), .out_valid(out_valid), .result(result)
    );

    // Exact model: integers in units of 2^-149, then one nearest-even rounding.
    function automatic logic [31:0] ref_fma(input logic [15:0] a, input logic [15:0] b, input logic [31:0] c);
        logic an, bn, cn, ai, bi, ci, az, bz, ps, cs, rs, up;
        logic [299:0] pv, cv, mv, rem, half;
        logic [24:0] q;
        int xa, xb, h, s, e;
        an = (a[14:10] == 5'h1F) && (a[9:0] != 0);
        bn = (b[14:10] == 5'h1F) && (b[9:0] != 0);
        cn = (c[30:23] == 8'hFF) && (c[22:0] != 0);
        ai = (a[14:10] == 5'h1F) && (a[9:0] == 0);
        bi = (b[14:10] == 5'h1F) && (b[9:0] == 0);
        ci = (c[30:23] == 8'hFF) && (c[22:0] == 0);
        az = (a[14:0] == 0);
        bz = (b[14:0] == 0);
        ps = a[15] ^ b[15];
        cs = c[31];
        if (an || bn || cn || (ai && bz) || (bi && az)) return 32'h7FC0_0000;
        if (ai || bi) return (ci && cs != ps) ? 32'h7FC0_0000 : {ps, 8'hFF, 23'd0};
        if (ci) return c;
        xa = (a[14:10] == 0) ? -14 : int'(a[14:10]) - 15;
        xb = (b[14:10] == 0) ? -14 : int'(b[14:10]) - 15;
        pv = 300'({a[14:10] != 0, a[9:0]}) * 300'({b[14:10] != 0, b[9:0]});
        pv = pv << (xa + xb + 129);
        cv = 300'({c[30:23] != 0, c[22:0]});
        cv = cv << ((c[30:23] == 0) ? 0 : int'(c[30:23]) - 1);
        if (ps == cs)      begin mv = pv + cv; rs = ps; end
        else if (pv >= cv) begin mv = pv - cv; rs = ps; end
        else               begin mv = cv - pv; rs = cs; end
        if (mv == 0) return {(pv == 0) && ps && cs, 31'd0};
        h = 0;
        for (int i = 0; i < 300; i++) if (mv[i]) h = i;
        if (h < 24) return {rs, (h == 23) ? 8'd1 : 8'd0, mv[22:0]};
        s = h - 23;
        q = 25'(mv >> s);
        rem = mv & ((300'd1 << s) - 300'd1);
        half = 300'd1 << (s - 1);
        up = (rem > half) || (rem == half && q[0]);
        q = q + 25'(up);
        e = h - 22;
        if (q[24]) begin q = q >> 1; e = e + 1; end
        if (e >= 255) return {rs, 8'hFF, 23'd0};
        return {rs, 8'(e), q[22:0]};
    endfunction

    // Compare the output due now, then issue the next operation.
    task automatic tick(input logic v, input logic [15:0] a, input logic [15:0] b,
                        input logic [31:0] c, input string tag);
        @(negedge clk);
        n_checks++;
        if (out_valid !== hv[2]) begin
            n_err++;
            $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, hv[2]);
        end
        if (hv[2]) begin
            n_checks++;
            if (result !== hr[2]) begin
                n_err++;
                $display("FAIL %s result actual=%08h expected=%08h", ht[2], result, hr[2]);
            end
        end
        hv[2] = hv[1]; hr[2] = hr[1]; ht[2] = ht[1];
        hv[1] = hv[0]; hr[1] = hr[0]; ht[1] = ht[0];
        hv[0] = v;
        hr[0] = v ? ref_fma(a, b, c) : 32'd0;
        ht[0] = tag;
        in_valid = v; op_a = a; op_b = b; addend = c;
    endtask

    function automatic logic [15:0] rnd_half();
        logic [15:0] v;
        v = 16'($urandom);
        if (v[14:10] == 5'h1F) v[14] = 1'b0;
        return v;
    endfunction

    initial begin
        for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hr[i] = '0; ht[i] = "R2"; end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || result !== 32'd0) begin
            n_err++;
            $display("FAIL R10 reset outputs actual=%0b/%08h expected=0/00000000", out_valid, result);
        end
        rst_n = 1'b1;
        // R1 directed ties: 1.0 + 2^-24 stays even, odd significand rounds up
        tick(1, 16'h0001, 16'h3C00, 32'h3F80_0000, "R1");
        tick(1, 16'h0001, 16'h3C00, 32'h3F80_0001, "R1");
        tick(1, 16'h3555, 16'hC7FF, 32'h4120_0000, "R1");
        // R3 subnormal factors
        tick(1, 16'h0001, 16'h0001, 32'h0000_0000, "R3");
        tick(1, 16'h83FF, 16'h0200, 32'h2F00_0000, "R3");
        // R4 massive cancellation
        tick(1, 16'h3E00, 16'h3E00, 32'hC010_0001, "R4");
        tick(1, 16'h3BFF, 16'h3BFF, 32'hBF7F_C002, "R4");
        // R5 NaN inputs
        tick(1, 16'h7E01, 16'h3C00, 32'h3F80_0000, "R5");
        tick(1, 16'h3C00, 16'h3C00, 32'h7F80_0001, "R5");
        // R6 invalid combinations
        tick(1, 16'h7C00, 16'h0000, 32'h0000_0000, "R6");
        tick(1, 16'h7C00, 16'h3C00, 32'hFF80_0000, "R6");
        // R7 infinity propagation
        tick(1, 16'hFC00, 16'h3C00, 32'h3F80_0000, "R7");
        tick(1, 16'h3C00, 16'h3C00, 32'h7F80_0000, "R7");
        // R8 zero signs
        tick(1, 16'h3C00, 16'h3C00, 32'hBF80_0000, "R8");
        tick(1, 16'h8000, 16'h3C00, 32'h8000_0000, "R8");
        tick(1, 16'h8000, 16'h3C00, 32'h0000_0000, "R8");
        // R9 zero product passes the addend, subnormal addend included
        tick(1, 16'h0000, 16'h1234, 32'h0000_0005, "R9");
        tick(1, 16'h8000, 16'h0001, 32'hC2F6_8000, "R9");
        // Random mix with bubbles (R2) and targeted addends
        for (int n = 0; n < 2500; n++) begin
            logic [15:0] a, b;
            logic [31:0] c, p;
            int mode, ce;
            string tag;
            mode = int'($urandom % 4);
            a = rnd_half();
            b = rnd_half();
            c = $urandom;
            tag = "R1";
            p = ref_fma(a, b, 32'd0);
            if (mode == 0) begin
                a = 16'($urandom); b = 16'($urandom);
            end else if (mode == 1) begin
                tag = "R4";
                if (p[30:0] != 0) c = (p ^ 32'h8000_0000) + 32'(int'($urandom % 9) - 4);
            end else if (mode == 2) begin
                tag = "R3";
                a = {a[15], 5'd0, a[9:0]};
            end else begin
                ce = (p[30:23] == 0) ? 100 : int'(p[30:23]);
                ce = ce + int'($urandom % 51) - 25;
                if (ce < 1) ce = 1;
                if (ce > 254) ce = 254;
                c = {c[31], 8'(ce), c[22:0]};
            end
            tick(($urandom % 5) != 0, a, b, c, tag);
        end
        repeat (4) tick(0, 16'd0, 16'd0, 32'd0, "R2");
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_err++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule